// File: doc/BRIEF.md
# Four-Sequencer Sample Trigger Controller

This block sits in front of an analog-to-digital converter and runs four independent sample sequencers behind a small register bus. When an external trigger pulse arrives, every sequencer that is enabled and whose trigger-source field selects the external trigger produces one conversion result. It pushes that result into its own 16-entry result queue and flags a raw interrupt. Each sequencer has its own interrupt line, gated by a per-sequencer mask bit.

The conversion result is synthetic. A shared 32-bit linear-congruential generator steps once for each responding sequencer, in ascending sequencer order. The sample is a fixed base of 0x200 plus three bits taken from the new generator state. Software reads results by reading a per-sequencer data register, which pops the oldest entry. Queue overflow and underflow are recorded in sticky status bits that are cleared by writing 1.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The enable register at offset 0x00 keeps only bits [3:0]; bit n enables sequencer n, and higher written bits read back as 0.
- R2: The trigger-select register at offset 0x18 holds a 4-bit field for sequencer n at bits [4n+3:4n]. On a trigger_i pulse, sequencer n responds only when it is enabled and its field equals 5.
- R3: For each responding sequencer, taken in order 0 to 3, the noise state becomes noise*314159+1 (mod 2^32), and that sequencer's sample is 0x200 + noise[18:16] of the new state. The noise still advances when the sequencer's queue is full, and it is unchanged by a trigger with no responders.
- R4: A responding sequencer sets raw status bit n, readable at 0x04. Writing 1 to bit n at 0x0C clears it. A response in the same cycle as the clear wins.
- R5: irq_o[n] is high exactly when raw bit n and mask bit n (mask register at 0x08) are both set. A read of 0x0C returns the masked status.
- R6: Each sequencer has a 16-entry first-in first-out queue. A read of 0x20+4n returns and pops its oldest entry.
- R7: A sample pushed into a full queue is dropped and sets overflow bit n at 0x10. Writing 1 to bit n at 0x10 clears it.
- R8: A read of an empty queue returns the value most recently popped from that queue (0 after reset) and sets underflow bit n at 0x14. Writing 1 to bit n at 0x14 clears it.
- R9: After reset, all enables, masks, select fields, status bits and queues are clear, the noise state is zero, irq_o is 0, and unmapped offsets read 0.
- R10: Read data is registered: bus_rdata_o shows the addressed value in the cycle after the read request and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| trig_i | input | 1 | External trigger pulse, one cycle per event |
| irq_o | output | 4 | Per-sequencer masked interrupt |

## Verification
The bench builds the block with its default parameters: four sequencers, 4-bit select fields and 16-entry queues. With four sequencers, all 256 combinations of enable mask and select-match pattern can be swept. Each combination is followed by a drain of every queue against a bench-side generator model, which covers both response gating and the in-order noise stepping. The 16-entry depth keeps a full overflow run cheap, followed by an underflow read and a post-overflow sample that shows the generator kept stepping. A further sweep covers all 16 mask values.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [7:0] OFF_EN    = 8'h00;
  localparam logic [7:0] OFF_RAW   = 8'h04;
  localparam logic [7:0] OFF_MASK  = 8'h08;
  localparam logic [7:0] OFF_MIS   = 8'h0C;
  localparam logic [7:0] OFF_OVF   = 8'h10;
  localparam logic [7:0] OFF_UNF   = 8'h14;
  localparam logic [7:0] OFF_SEL   = 8'h18;
  localparam logic [7:0] OFF_FIFO  = 8'h20;

  localparam logic [31:0] LCG_MULT    = 32'd314159;
  localparam logic [31:0] LCG_INC     = 32'd1;
  localparam int unsigned EXT_TRIG    = 5;
  localparam int unsigned SAMPLE_BASE = 32'h200;

  function automatic logic [31:0] lcg_step(input logic [31:0] s);
    return s * LCG_MULT + LCG_INC;
  endfunction
endpackage

// File: rtl/adc_noise_chain.sv
module adc_noise_chain import adc_seq_pkg::*; #(
  parameter int NUM_SEQ  = 4,
  parameter int SAMPLE_W = 10
) (
  input  logic [31:0]                        noise_i,
  input  logic [NUM_SEQ-1:0]                 resp_i,
  output logic [31:0]                        noise_o,
  output logic [NUM_SEQ-1:0][SAMPLE_W-1:0]   sample_o
);
  logic [NUM_SEQ:0][31:0] chain;

  assign chain[0] = noise_i;

  // each responder advances the shared state once, lowest index first
  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_step
    assign chain[n+1]  = resp_i[n] ? lcg_step(chain[n]) : chain[n];
    assign sample_o[n] = SAMPLE_W'(SAMPLE_BASE) + SAMPLE_W'(chain[n+1][18:16]);
  end

  assign noise_o = chain[NUM_SEQ];
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     rd_data_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     last_q;
  logic             empty, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty;
  assign ovf_o   = push_i && full_o;
  assign unf_o   = pop_i && empty;
  assign cnt_o   = cnt;

  assign rd_data_o = empty ? last_q : mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      last_q <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) begin
        rd_ptr <= rd_ptr + 1'b1;
        last_q <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int NUM_SEQ    = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 4,
  parameter int SAMPLE_W   = 10,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int SELR_W    = NUM_SEQ * SEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               trig_i,
  output logic [NUM_SEQ-1:0] irq_o
);
  logic [NUM_SEQ-1:0] en_q, mask_q, raw_q, ovf_q, unf_q;
  logic [SELR_W-1:0]  sel_q;
  logic [31:0]        noise_q, noise_d;
  logic [DATA_W-1:0]  rdata_q, rd_mux;

  logic [NUM_SEQ-1:0]                resp, pop, fifo_full, fifo_ovf, fifo_unf;
  logic [NUM_SEQ-1:0][SAMPLE_W-1:0]  sample, fifo_rd;
  logic [NUM_SEQ-1:0][CNT_W-1:0]     fifo_cnt;

  logic wr, rd;
  assign wr = bus_req_i && bus_we_i;
  assign rd = bus_req_i && !bus_we_i;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
    assign resp[n] = trig_i && en_q[n] &&
                     (sel_q[n*SEL_W +: SEL_W] == SEL_W'(EXT_TRIG));
    assign pop[n]  = rd && (bus_addr_i == ADDR_W'(OFF_FIFO + 8'(4*n)));

    adc_seq_fifo #(.DEPTH(FIFO_DEPTH), .W(SAMPLE_W)) u_fifo (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .push_i    (resp[n]),
      .data_i    (sample[n]),
      .pop_i     (pop[n]),
      .rd_data_o (fifo_rd[n]),
      .full_o    (fifo_full[n]),
      .ovf_o     (fifo_ovf[n]),
      .unf_o     (fifo_unf[n]),
      .cnt_o     (fifo_cnt[n])
    );
  end

  adc_noise_chain #(.NUM_SEQ(NUM_SEQ), .SAMPLE_W(SAMPLE_W)) u_noise (
    .noise_i  (noise_q),
    .resp_i   (resp),
    .noise_o  (noise_d),
    .sample_o (sample)
  );

  // write-one-to-clear masks
  logic [NUM_SEQ-1:0] clr_raw, clr_ovf, clr_unf;
  assign clr_raw = (wr && hit(bus_addr_i, OFF_MIS)) ? bus_wdata_i[NUM_SEQ-1:0] : '0;
  assign clr_ovf = (wr && hit(bus_addr_i, OFF_OVF)) ? bus_wdata_i[NUM_SEQ-1:0] : '0;
  assign clr_unf = (wr && hit(bus_addr_i, OFF_UNF)) ? bus_wdata_i[NUM_SEQ-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mask_q  <= '0;
      sel_q   <= '0;
      raw_q   <= '0;
      ovf_q   <= '0;
      unf_q   <= '0;
      noise_q <= '0;
    end else begin
      if (wr && hit(bus_addr_i, OFF_EN))   en_q   <= bus_wdata_i[NUM_SEQ-1:0];
      if (wr && hit(bus_addr_i, OFF_MASK)) mask_q <= bus_wdata_i[NUM_SEQ-1:0];
      if (wr && hit(bus_addr_i, OFF_SEL))  sel_q  <= bus_wdata_i[SELR_W-1:0];
      raw_q   <= (raw_q & ~clr_raw) | resp;
      ovf_q   <= (ovf_q & ~clr_ovf) | fifo_ovf;
      unf_q   <= (unf_q & ~clr_unf) | fifo_unf;
      noise_q <= noise_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      ADDR_W'(OFF_EN):   rd_mux = DATA_W'(en_q);
      ADDR_W'(OFF_RAW):  rd_mux = DATA_W'(raw_q);
      ADDR_W'(OFF_MASK): rd_mux = DATA_W'(mask_q);
      ADDR_W'(OFF_MIS):  rd_mux = DATA_W'(raw_q & mask_q);
      ADDR_W'(OFF_OVF):  rd_mux = DATA_W'(ovf_q);
      ADDR_W'(OFF_UNF):  rd_mux = DATA_W'(unf_q);
      ADDR_W'(OFF_SEL):  rd_mux = DATA_W'(sel_q);
      default: begin
        for (int n = 0; n < NUM_SEQ; n++)
          if (pop[n]) rd_mux = DATA_W'(fifo_rd[n]);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = raw_q & mask_q;
endmodule

// File: rtl/adc_seq_ctrl_sva.sv
module adc_seq_ctrl_sva #(
  parameter int NUM_SEQ    = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            trig_i,
  input logic [NUM_SEQ-1:0]              en_q,
  input logic [NUM_SEQ-1:0]              resp,
  input logic [NUM_SEQ-1:0]              raw_q,
  input logic [NUM_SEQ-1:0]              ovf_q,
  input logic [NUM_SEQ-1:0]              fifo_full,
  input logic [NUM_SEQ-1:0][CNT_W-1:0]   fifo_cnt,
  input logic [31:0]                     noise_q
);
  for (genvar n = 0; n < NUM_SEQ; n++) begin : g_chk
    assert_resp_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp[n] |-> (trig_i && en_q[n]));
    assert_raw_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resp[n] |=> raw_q[n]);
    assert_ovf_on_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resp[n] && fifo_full[n]) |=> ovf_q[n]);
    assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fifo_cnt[n] <= CNT_W'(FIFO_DEPTH));
  end

  assert_noise_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp == '0) |=> $stable(noise_q));
  assert_noise_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp != '0) |=> !$stable(noise_q) || ($countones(resp) == 0));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_sva #(
  .NUM_SEQ(NUM_SEQ), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trig_i    (trig_i),
  .en_q      (en_q),
  .resp      (resp),
  .raw_q     (raw_q),
  .ovf_q     (ovf_q),
  .fifo_full (fifo_full),
  .fifo_cnt  (fifo_cnt),
  .noise_q   (noise_q)
);

// File: tb/adc_seq_ctrl_tb_top.sv
module adc_seq_ctrl_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0, trig = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int tests = 0, fails = 0;
  logic [31:0] noise_m = '0;
  logic [31:0] last_m [4];
  logic [31:0] r;

  always #2.5 clk = ~clk;

  adc_seq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .trig_i(trig), .irq_o(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bread(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  function automatic logic [31:0] next_sample();
    noise_m = noise_m * 32'd314159 + 32'd1;
    return 32'h200 + ((noise_m >> 16) & 32'h7);
  endfunction

  task automatic pulse();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] exp_s [4];
    logic [31:0] ovf_s [18];
    for (int n = 0; n < 4; n++) last_m[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R9 reset state
    chk("R9 irq", {28'h0, irq}, 32'h0);
    for (int a = 0; a < 8'h1C; a += 4) begin
      bread(8'(a), r); chk("R9 reg", r, 32'h0);
    end
    bread(8'h40, r); chk("R9 unmapped", r, 32'h0);

    // R8 empty read after reset returns 0, sets underflow
    bread(8'h24, r); chk("R8 empty data", r, 32'h0);
    bread(8'h14, r); chk("R8 unf bit", r, 32'h2);
    // R10 data holds until next read
    bwrite(8'h08, 32'h0);
    chk("R10 hold", rdata, 32'h2);
    bwrite(8'h14, 32'h2);
    bread(8'h14, r); chk("R8 unf clear", r, 32'h0);

    // R1 enable keeps low bits only
    bwrite(8'h00, 32'hFFFF_FFFF);
    bread(8'h00, r); chk("R1 en width", r, 32'hF);

    // R2 R3 R4 R6 sweep of enable x select-match
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 16; s++) begin
        logic [15:0] selv;
        for (int n = 0; n < 4; n++) begin
          int alt;
          alt = (e + n) & 15;
          if (alt == 5) alt = 6;
          selv[n*4 +: 4] = s[n] ? 4'd5 : 4'(alt);
        end
        bwrite(8'h00, 32'(e));
        bwrite(8'h18, 32'(selv));
        pulse();
        for (int n = 0; n < 4; n++)
          if (e[n] && s[n]) exp_s[n] = next_sample();
        bread(8'h04, r); chk("R2 R4 raw", r, 32'(e & s));
        for (int n = 0; n < 4; n++) begin
          if (e[n] && s[n]) begin
            bread(8'(8'h20 + 4*n), r); chk("R3 R6 sample", r, exp_s[n]);
            last_m[n] = exp_s[n];
          end
        end
        bwrite(8'h0C, 32'hF);
      end
    end
    bread(8'h04, r); chk("R4 clear", r, 32'h0);
    bread(8'h10, r); chk("R7 no ovf", r, 32'h0);
    bread(8'h14, r); chk("R8 no unf", r, 32'h0);
    bread(8'h18, r); chk("R2 sel readback", r[15:0] == 16'h5555 ? 32'h1 : 32'h0, 32'h1);

    // R4 set wins over same-cycle clear (seq 0 only)
    bwrite(8'h00, 32'h1);
    bwrite(8'h18, 32'h5);
    @(negedge clk); trig = 1; req = 1; we = 1; addr = 8'h0C; wdata = 32'hF;
    @(negedge clk); trig = 0; req = 0; we = 0;
    exp_s[0] = next_sample();
    bread(8'h04, r); chk("R4 set wins", r, 32'h1);
    bread(8'h20, r); chk("R3 sample", r, exp_s[0]);
    bwrite(8'h0C, 32'h1);

    // R7 overflow: 17 pushes into seq 0, then one more after draining
    for (int k = 0; k < 17; k++) begin
      pulse();
      ovf_s[k] = next_sample();
    end
    bread(8'h10, r); chk("R7 ovf bit", r, 32'h1);
    for (int k = 0; k < 16; k++) begin
      bread(8'h20, r); chk("R7 R6 order", r, ovf_s[k]);
    end
    bread(8'h20, r); chk("R7 dropped, R8 last", r, ovf_s[15]);
    bread(8'h14, r); chk("R8 unf set", r, 32'h1);
    bwrite(8'h10, 32'h1);
    bwrite(8'h14, 32'h1);
    bread(8'h10, r); chk("R7 ovf clear", r, 32'h0);
    bread(8'h14, r); chk("R8 unf clear", r, 32'h0);
    pulse();
    ovf_s[17] = next_sample();
    bread(8'h20, r); chk("R3 noise advanced on drop", r, ovf_s[17]);
    bwrite(8'h0C, 32'hF);

    // R3 trigger with no responders leaves noise alone
    bwrite(8'h18, 32'h0);
    pulse();
    bwrite(8'h18, 32'h5);
    pulse();
    exp_s[0] = next_sample();
    bread(8'h20, r); chk("R3 hold", r, exp_s[0]);

    // R5 mask sweep
    bwrite(8'h00, 32'hF);
    bwrite(8'h18, 32'h5555);
    pulse();
    for (int n = 0; n < 4; n++) exp_s[n] = next_sample();
    for (int m = 0; m < 16; m++) begin
      bwrite(8'h08, 32'(m));
      chk("R5 irq", {28'h0, irq}, 32'(m));
      bread(8'h0C, r); chk("R5 masked read", r, 32'(m));
    end
    bwrite(8'h0C, 32'h5);
    chk("R5 R4 partial clear", {28'h0, irq}, 32'hA);
    for (int n = 0; n < 4; n++) begin
      bread(8'(8'h20 + 4*n), r); chk("R3 order", r, exp_s[n]);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule